// File: doc/BRIEF.md
# NAND Flash Instruction Sequencer

This block executes a short program of NAND flash micro-operations after a single start strobe. The program is one 32-bit word with eight 4-bit opcode slots. Each opcode can send a command byte, send address bytes, wait for the device to become ready, or move data. Data moves either between the flash and a page buffer (byte-counted) or between the flash and a 16-bit data register (one or two bytes).

The sequencer drives an 8-bit NAND interface directly. It runs each byte as a one-cycle write or read strobe, with command-latch and address-latch enables set for the bytes that need them. It fills or drains a synchronous page-buffer port. At the end of the program it pulses `done` and reports either normal completion or a ready-wait timeout.

Top module: `nand_seq`

## Requirements
- R1: Opcode slots run from slot 0 (instruction bits 31:28) toward slot 7 (bits 3:0), one after another. When slot 7 has run the sequence ends, so up to eight operations execute per start.
- R2: Opcode 0x0 ends the sequence at once, and no later slot runs. Opcodes 0xF and 0x0 are the only ones that issue nothing; 0xF is skipped. When the sequence ends, `done` is high for exactly one cycle, `busy` falls and `cmd_done` is set.
- R3: Opcodes 0x4, 0x5, 0x6 and 0x7 each send one command byte with `cle` high and `ale` low. The byte is taken from `cmd_regs` bits 31:24, 23:16, 15:8 or 7:0 respectively.
- R4: Address bytes are sent with `ale` high and `cle` low, low byte first. Opcode 0x1 sends the column: with `large_page`=1 that is two bytes from `page_reg` bits 10:0, otherwise one byte from bits 7:0. Opcode 0x2 sends `row_len`+1 bytes of the row. The row is {`blk_num`, `page_reg`[17:12]} for large pages and {`blk_num`, `page_reg`[14:10]} for small pages. Opcode 0x3 sends the single byte `user_addr`.
- R5: Opcodes 0xC and 0xD first wait until `rb_n` is high and then send the command byte from bits 31:24 or 23:16 of `cmd_regs`. No strobe is issued while the wait lasts.
- R6: Opcode 0x8 sends `byte_count` bytes read from buffer addresses 0, 1, 2 and so on. Opcode 0xA reads `byte_count` bytes from the device into buffer addresses 0, 1, 2 and so on. Opcode 0xE first waits for ready and then behaves like 0xA. A count of zero moves no bytes.
- R7: Opcode 0x9 sends `data_wr` bits 7:0, followed by bits 15:8 when `two_bytes`=1. Opcode 0xB reads one byte into `data_rd` bits 7:0, or two bytes (the second into bits 15:8) when `two_bytes`=1, and clears the bits it does not fill.
- R8: If `rb_n` stays low for more than `wait_limit` cycles during a wait, the sequence aborts. No further strobe is issued, `timeout` is set, `cmd_done` stays clear and `done` pulses.
- R9: After reset `we_n` and `re_n` are high, and `cle`, `ale`, `busy`, `done`, `cmd_done` and `timeout` are low. A new start clears `cmd_done` and `timeout`.
- R10: Each byte uses a strobe that is low for exactly one cycle, the bus is driven while `we_n` is low, and `we_n` and `re_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin running the program (sampled when idle) |
| instr | input | 32 | Eight packed 4-bit opcodes |
| cmd_regs | input | 32 | Four command bytes |
| blk_num | input | 24 | Block number for the row address |
| page_reg | input | 32 | Page index and column |
| byte_count | input | 12 | Buffered transfer length |
| user_addr | input | 8 | User-defined address byte |
| data_wr | input | 16 | Single-transfer write data |
| two_bytes | input | 1 | Single transfers move two bytes |
| large_page | input | 1 | Selects the large-page address layout |
| row_len | input | 2 | Row address bytes minus one |
| wait_limit | input | 16 | Ready-wait timeout in cycles |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_out | output | 8 | Data driven to the device |
| io_oe | output | 1 | Output enable for io_out |
| io_in | input | 8 | Data from the device |
| rb_n | input | 1 | Ready (high) / busy (low) |
| buf_addr | output | 12 | Page-buffer address |
| buf_we | output | 1 | Page-buffer write enable |
| buf_wdata | output | 8 | Page-buffer write data |
| buf_rdata | input | 8 | Page-buffer read data, one cycle after address |
| data_rd | output | 16 | Single-transfer read data |
| busy | output | 1 | Program in progress |
| done | output | 1 | One-cycle end pulse |
| cmd_done | output | 1 | Program ended normally |
| timeout | output | 1 | Program aborted on ready wait |

## Verification
A device model on the bench logs every write strobe together with the latch enables, and returns a counting byte pattern on each read strobe. Command-only programs with distinct command bytes show that the slot order and the command-field mapping are right. Mixed programs ending in a NOP, a reserved opcode or a full eight slots show where the sequence ends. Address programs in the two page layouts, and with different row lengths, separate the column and row byte orders. Data programs with counts of zero, one, two and three separate the buffered paths from the single-byte paths. Holding ready low for a short time and for longer than the limit separates a wait that succeeds from an abort.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int BYTE_W = 8;

  localparam logic [3:0] OP_NOP  = 4'h0;
  localparam logic [3:0] OP_COL  = 4'h1;
  localparam logic [3:0] OP_ROW  = 4'h2;
  localparam logic [3:0] OP_UADR = 4'h3;
  localparam logic [3:0] OP_BUFW = 4'h8;
  localparam logic [3:0] OP_SW   = 4'h9;
  localparam logic [3:0] OP_BUFR = 4'hA;
  localparam logic [3:0] OP_SR   = 4'hB;
  localparam logic [3:0] OP_WC0  = 4'hC;
  localparam logic [3:0] OP_WC1  = 4'hD;
  localparam logic [3:0] OP_WRD  = 4'hE;

  typedef enum logic [2:0] {
    K_CMD, K_COL, K_ROW, K_UA, K_BUFW, K_SW, K_BUFR, K_SR
  } kind_t;

  typedef enum logic [3:0] {
    S_IDLE, S_DEC, S_WAIT, S_LOAD, S_FETCH, S_FETCH2,
    S_WLO, S_WHI, S_RLO, S_RHI, S_NEXT, S_END
  } state_t;
endpackage

// File: rtl/nand_byte_src.sv
module nand_byte_src
  import nand_seq_pkg::*;
#(
  parameter int BLK_W = 24
) (
  input  kind_t              kind,
  input  logic [1:0]         idx,
  input  logic [1:0]         cmd_sel,
  input  logic [31:0]        cmd_regs,
  input  logic               large_page,
  input  logic [31:0]        page_reg,
  input  logic [BLK_W-1:0]   blk_num,
  input  logic [BYTE_W-1:0]  user_addr,
  input  logic [15:0]        data_wr,
  input  logic [BYTE_W-1:0]  buf_rdata,
  output logic [BYTE_W-1:0]  tx_byte
);
  localparam int ROW_W = BLK_W + 6;

  logic [ROW_W-1:0] row_full;
  logic [ROW_W-1:0] row_sh;
  logic [10:0]      col;
  logic [31:0]      cmd_sh;

  always_comb begin
    if (large_page) row_full = {blk_num, page_reg[17:12]};
    else            row_full = {1'b0, blk_num, page_reg[14:10]};
    row_sh = row_full >> (8 * idx);
    col    = large_page ? page_reg[10:0] : {3'b000, page_reg[7:0]};
    cmd_sh = cmd_regs << (8 * cmd_sel);
  end

  always_comb begin
    unique case (kind)
      K_CMD:   tx_byte = cmd_sh[31:24];
      K_COL:   tx_byte = idx[0] ? {5'b00000, col[10:8]} : col[7:0];
      K_ROW:   tx_byte = row_sh[7:0];
      K_UA:    tx_byte = user_addr;
      K_SW:    tx_byte = idx[0] ? data_wr[15:8] : data_wr[7:0];
      K_BUFW:  tx_byte = buf_rdata;
      default: tx_byte = '0;
    endcase
  end
endmodule

// File: rtl/nand_ready_wait.sv
module nand_ready_wait #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             rb_n,
  input  logic [TMO_W-1:0] limit,
  output logic             ready,
  output logic             expired
);
  logic [TMO_W-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) lo_cnt <= '0;
    else if (!rb_n && lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
  end

  assign ready   = en && rb_n;
  assign expired = en && !rb_n && (lo_cnt >= limit);
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int BLK_W = 24,
  parameter int TMO_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       instr,
  input  logic [31:0]       cmd_regs,
  input  logic [BLK_W-1:0]  blk_num,
  input  logic [31:0]       page_reg,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [7:0]        user_addr,
  input  logic [15:0]       data_wr,
  input  logic              two_bytes,
  input  logic              large_page,
  input  logic [1:0]        row_len,
  input  logic [TMO_W-1:0]  wait_limit,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [7:0]        io_out,
  output logic              io_oe,
  input  logic [7:0]        io_in,
  input  logic              rb_n,
  output logic [CNT_W-1:0]  buf_addr,
  output logic              buf_we,
  output logic [7:0]        buf_wdata,
  input  logic [7:0]        buf_rdata,
  output logic [15:0]       data_rd,
  output logic              busy,
  output logic              done,
  output logic              cmd_done,
  output logic              timeout
);
  localparam int SLOTS = 8;
  localparam int SLOT_W = $clog2(SLOTS);

  state_t             state;
  kind_t              kind;
  logic [31:0]        ir;
  logic [SLOT_W-1:0]  slot;
  logic [1:0]         cmd_sel;
  logic [CNT_W-1:0]   idx;
  logic [CNT_W-1:0]   n;
  logic [3:0]         op;
  logic [BYTE_W-1:0]  tx_byte;
  logic               more;
  logic               rdy;
  logic               expired;
  logic               is_addr;

  assign op      = ir[31:28];
  assign more    = ({1'b0, idx} + 1'b1) < {1'b0, n};
  assign is_addr = (kind == K_COL) || (kind == K_ROW) || (kind == K_UA);

  nand_byte_src #(.BLK_W(BLK_W)) u_src (
    .kind(kind), .idx(idx[1:0]), .cmd_sel(cmd_sel), .cmd_regs(cmd_regs),
    .large_page(large_page), .page_reg(page_reg), .blk_num(blk_num),
    .user_addr(user_addr), .data_wr(data_wr), .buf_rdata(buf_rdata),
    .tx_byte(tx_byte)
  );

  nand_ready_wait #(.TMO_W(TMO_W)) u_wait (
    .clk(clk), .rst(rst), .en(state == S_WAIT), .rb_n(rb_n),
    .limit(wait_limit), .ready(rdy), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      kind     <= K_CMD;
      ir       <= '0;
      slot     <= '0;
      cmd_sel  <= '0;
      idx      <= '0;
      n        <= '0;
      cle      <= 1'b0;
      ale      <= 1'b0;
      we_n     <= 1'b1;
      re_n     <= 1'b1;
      io_out   <= '0;
      io_oe    <= 1'b0;
      buf_addr <= '0;
      buf_we   <= 1'b0;
      buf_wdata<= '0;
      data_rd  <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      cmd_done <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          ir       <= instr;
          slot     <= '0;
          busy     <= 1'b1;
          cmd_done <= 1'b0;
          timeout  <= 1'b0;
          state    <= S_DEC;
        end
        S_DEC: begin
          idx   <= '0;
          state <= S_LOAD;
          case (op)
            OP_NOP: state <= S_END;
            4'h4, 4'h5, 4'h6, 4'h7: begin
              kind <= K_CMD; cmd_sel <= op[1:0]; n <= CNT_W'(1);
            end
            OP_WC0, OP_WC1: begin
              kind <= K_CMD; cmd_sel <= {1'b0, op[0]}; n <= CNT_W'(1);
              state <= S_WAIT;
            end
            OP_WRD: begin
              kind <= K_BUFR; n <= byte_count; state <= S_WAIT;
            end
            OP_COL:  begin kind <= K_COL; n <= large_page ? CNT_W'(2) : CNT_W'(1); end
            OP_ROW:  begin kind <= K_ROW; n <= CNT_W'(row_len) + 1'b1; end
            OP_UADR: begin kind <= K_UA;  n <= CNT_W'(1); end
            OP_BUFW: begin kind <= K_BUFW; n <= byte_count; end
            OP_SW:   begin kind <= K_SW; n <= two_bytes ? CNT_W'(2) : CNT_W'(1); end
            OP_BUFR: begin kind <= K_BUFR; n <= byte_count; end
            OP_SR: begin
              kind <= K_SR; n <= two_bytes ? CNT_W'(2) : CNT_W'(1);
              data_rd <= '0;
            end
            default: state <= S_NEXT;
          endcase
        end
        S_WAIT: begin
          if (rdy) state <= S_LOAD;
          else if (expired) begin
            timeout <= 1'b1;
            state   <= S_END;
          end
        end
        S_LOAD: begin
          if (n == '0) state <= S_NEXT;
          else if (kind == K_BUFR || kind == K_SR) begin
            re_n  <= 1'b0;
            state <= S_RLO;
          end else if (kind == K_BUFW) begin
            buf_addr <= idx;
            state    <= S_FETCH;
          end else begin
            io_out <= tx_byte;
            io_oe  <= 1'b1;
            cle    <= (kind == K_CMD);
            ale    <= is_addr;
            we_n   <= 1'b0;
            state  <= S_WLO;
          end
        end
        S_FETCH: state <= S_FETCH2;
        S_FETCH2: begin
          io_out <= tx_byte;
          io_oe  <= 1'b1;
          cle    <= 1'b0;
          ale    <= 1'b0;
          we_n   <= 1'b0;
          state  <= S_WLO;
        end
        S_WLO: begin
          we_n  <= 1'b1;
          state <= S_WHI;
        end
        S_WHI: begin
          if (more) begin
            idx   <= idx + 1'b1;
            state <= S_LOAD;
          end else begin
            cle   <= 1'b0;
            ale   <= 1'b0;
            io_oe <= 1'b0;
            state <= S_NEXT;
          end
        end
        S_RLO: begin
          re_n <= 1'b1;
          if (kind == K_BUFR) begin
            buf_we    <= 1'b1;
            buf_addr  <= idx;
            buf_wdata <= io_in;
          end else if (idx[0]) data_rd[15:8] <= io_in;
          else data_rd[7:0] <= io_in;
          state <= S_RHI;
        end
        S_RHI: begin
          buf_we <= 1'b0;
          if (more) begin
            idx   <= idx + 1'b1;
            state <= S_LOAD;
          end else state <= S_NEXT;
        end
        S_NEXT: begin
          ir   <= ir << 4;
          slot <= slot + 1'b1;
          state <= (slot == SLOT_W'(SLOTS - 1)) ? S_END : S_DEC;
        end
        S_END: begin
          done     <= 1'b1;
          busy     <= 1'b0;
          cmd_done <= !timeout;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic clk,
  input logic rst,
  input logic cle,
  input logic ale,
  input logic we_n,
  input logic re_n,
  input logic io_oe,
  input logic busy,
  input logic done,
  input logic cmd_done,
  input logic timeout
);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!we_n && !re_n));
  // R10
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst) !we_n |=> we_n);
  // R10
  re_pulse_chk: assert property (@(posedge clk) disable iff (rst) !re_n |=> re_n);
  // R10
  we_drive_chk: assert property (@(posedge clk) disable iff (rst) !we_n |-> io_oe);
  // R3
  latch_excl_chk: assert property (@(posedge clk) disable iff (rst) !(cle && ale));
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R8
  done_status_chk: assert property (@(posedge clk) disable iff (rst) done |-> (cmd_done ^ timeout));
endmodule

bind nand_seq nand_seq_chk u_chk (
  .clk(clk), .rst(rst), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
  .io_oe(io_oe), .busy(busy), .done(done), .cmd_done(cmd_done), .timeout(timeout)
);

// File: tb/nand_seq_bench.sv
module nand_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] cmd_regs = 32'h10307090;
  logic [23:0] blk_num = 24'h000ABC;
  logic [31:0] page_reg = 32'h00005123;
  logic [11:0] byte_count = '0;
  logic [7:0]  user_addr = 8'h5A;
  logic [15:0] data_wr = 16'hBEEF;
  logic        two_bytes = 1'b0;
  logic        large_page = 1'b1;
  logic [1:0]  row_len = 2'd1;
  logic [15:0] wait_limit = 16'd100;
  logic        cle, ale, we_n, re_n, io_oe;
  logic [7:0]  io_out;
  logic [7:0]  io_in = '0;
  logic        rb_n = 1'b1;
  logic [11:0] buf_addr;
  logic        buf_we;
  logic [7:0]  buf_wdata;
  logic [7:0]  buf_rdata;
  logic [15:0] data_rd;
  logic        busy, done, cmd_done, timeout;

  always #10 clk = ~clk;

  nand_seq u_nand_seq (.*);

  // page buffer model
  logic [7:0] mem [16];
  logic       tb_we = 1'b0;
  logic [3:0] tb_addr = '0;
  logic [7:0] tb_data = '0;
  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_data;
    else if (buf_we) mem[buf_addr[3:0]] <= buf_wdata;
    buf_rdata <= mem[buf_addr[3:0]];
  end

  // device model
  logic       log_en = 1'b0;
  int         ln = 0;
  logic [7:0] lb [64];
  logic       lc [64];
  logic       la [64];
  logic [7:0] rd_base = 8'h60;
  int         rd_k = 0;
  always @(posedge we_n) if (log_en && ln < 64) begin
    lb[ln] = io_out; lc[ln] = cle; la[ln] = ale; ln = ln + 1;
  end
  always @(negedge re_n) if (log_en) begin
    io_in = rd_base + 8'(rd_k); rd_k = rd_k + 1;
  end

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic run_seq(input logic [31:0] ins);
    int k;
    instr = ins; ln = 0; rd_k = 0; log_en = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    k = 0;
    while (!done && k < 20000) begin
      @(negedge clk); k++;
    end
    if (k >= 20000) check("R2 done seen", 0, 1);
  endtask

  task automatic preload(input int a, input logic [7:0] d);
    @(negedge clk); tb_we = 1'b1; tb_addr = 4'(a); tb_data = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  // instr, command count, address count, last byte
  localparam logic [55:0] VECS [5] = '{
    {32'h41200000, 8'd1, 8'd4, 8'hAF},
    {32'h71000000, 8'd1, 8'd2, 8'h01},
    {32'h56473000, 8'd4, 8'd1, 8'h5A},
    {32'h00000000, 8'd0, 8'd0, 8'h00},
    {32'hF4000000, 8'd1, 8'd0, 8'h10}
  };

  int ln_at;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 we_n", we_n, 1);
    check("R9 re_n", re_n, 1);
    check("R9 cle/ale", {cle, ale}, 0);
    check("R9 busy/done", {busy, done}, 0);
    check("R9 flags", {cmd_done, timeout}, 0);

    // table walk: R1 R2 R3 R4
    for (int v = 0; v < 5; v++) begin
      int nc, na;
      run_seq(VECS[v][55:24]);
      nc = 0; na = 0;
      for (int i = 0; i < ln; i++) begin
        if (lc[i]) nc++;
        if (la[i]) na++;
      end
      check("R3 command count", nc, int'(VECS[v][23:16]));
      check("R4 address count", na, int'(VECS[v][15:8]));
      if (ln > 0) check("R1 last byte", lb[ln-1], int'(VECS[v][7:0]));
      check("R2 cmd_done", cmd_done, 1);
    end

    // R1 order
    run_seq(32'h45000000);
    check("R1 first", lb[0], 8'h10);
    check("R1 second", lb[1], 8'h30);
    // R2 NOP ends early
    run_seq(32'h40500000);
    check("R2 nop stops", ln, 1);
    // R1 all eight slots
    run_seq(32'h44444445);
    check("R1 eight slots", ln, 8);
    check("R1 slot7 byte", lb[7], 8'h30);

    // R4 large page, three row bytes
    row_len = 2'd2;
    run_seq(32'h12000000);
    check("R4 large count", ln, 5);
    check("R4 col lo", lb[0], 8'h23);
    check("R4 col hi", lb[1], 8'h01);
    check("R4 row0", lb[2], 8'h05);
    check("R4 row1", lb[3], 8'hAF);
    check("R4 row2", lb[4], 8'h02);
    check("R4 ale/cle", {la[4], lc[4]}, 2'b10);
    // R4 small page
    large_page = 1'b0; row_len = 2'd0; page_reg = 32'h00000C45;
    run_seq(32'h12000000);
    check("R4 small count", ln, 2);
    check("R4 small col", lb[0], 8'h45);
    check("R4 small row", lb[1], 8'h83);
    large_page = 1'b1; row_len = 2'd1; page_reg = 32'h00005123;

    // R6 buffered write
    preload(0, 8'hA1); preload(1, 8'hA2); preload(2, 8'hA3);
    byte_count = 12'd3;
    run_seq(32'h80000000);
    check("R6 write count", ln, 3);
    check("R6 write b0", lb[0], 8'hA1);
    check("R6 write b2", lb[2], 8'hA3);
    check("R6 write latches", {la[1], lc[1]}, 0);
    // R6 zero count
    byte_count = 12'd0;
    run_seq(32'h80000000);
    check("R6 zero count", ln, 0);
    check("R6 zero cmd_done", cmd_done, 1);
    // R6 buffered read
    byte_count = 12'd3; rd_base = 8'h60;
    run_seq(32'hA0000000);
    @(negedge clk);
    check("R6 read m0", mem[0], 8'h60);
    check("R6 read m1", mem[1], 8'h61);
    check("R6 read m2", mem[2], 8'h62);

    // R7 single transfers
    two_bytes = 1'b1;
    run_seq(32'h90000000);
    check("R7 write count", ln, 2);
    check("R7 write lo", lb[0], 8'hEF);
    check("R7 write hi", lb[1], 8'hBE);
    two_bytes = 1'b0;
    run_seq(32'h90000000);
    check("R7 write one", ln, 1);
    two_bytes = 1'b1; rd_base = 8'h70;
    run_seq(32'hB0000000);
    check("R7 read two", data_rd, 16'h7170);
    two_bytes = 1'b0;
    run_seq(32'hB0000000);
    check("R7 read one", data_rd, 16'h0070);

    // R5 wait then CMD1
    rb_n = 1'b0;
    fork
      run_seq(32'hD0000000);
      begin
        repeat (20) @(negedge clk);
        ln_at = ln;
        rb_n = 1'b1;
      end
    join
    check("R5 no strobe while busy", ln_at, 0);
    check("R5 cmd after ready", lb[0], 8'h30);
    check("R5 no timeout", timeout, 0);

    // R8 timeout abort
    wait_limit = 16'd10; rb_n = 1'b0;
    run_seq(32'hC4000000);
    check("R8 timeout", timeout, 1);
    check("R8 cmd_done", cmd_done, 0);
    check("R8 no strobes", ln, 0);
    rb_n = 1'b1; wait_limit = 16'd100;
    // R9 flags cleared by new start
    run_seq(32'h40000000);
    check("R9 timeout cleared", timeout, 0);
    check("R9 cmd_done", cmd_done, 1);

    // R6 wait then read
    byte_count = 12'd2; rd_base = 8'h40; rb_n = 1'b0;
    fork
      run_seq(32'hE0000000);
      begin repeat (8) @(negedge clk); rb_n = 1'b1; end
    join
    @(negedge clk);
    check("R6 waitread m0", mem[0], 8'h40);
    check("R6 waitread m1", mem[1], 8'h41);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule